// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps the coherence state of every line of a small private direct-mapped cache that shares a snooping bus with peer caches. The processor side presents one read or write at a time. A read that finds a valid line, or a write to a line this cache already owns, completes in the same cycle with no bus traffic. Every other access raises a bus request. When the arbiter grants the bus, the block issues exactly one transaction per granted cycle: a write-back of a dirty victim, an invalidate, a read, or a read-for-ownership.

On the snoop side the block watches transactions from other caches. It answers a read to a line it holds by raising a shared indication. It hands its line over when that line is dirty, and it drops its copy when another cache claims ownership. Coherence is tracked per line. A line holds several words, and any access to any word of a line acts on the whole line.

Each bus transaction completes within its granted cycle. Memory and the peer caches answer combinationally: line data on `bus_rdata_i`, and the peers' shared wire on `bus_shared_i`. The bus is never granted to this cache in a cycle where a snoop is presented.

Top module: `coh_mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid. No snooped read finds a line, and the first processor access to any line needs the bus.
- R2: A read whose line is valid (Modified, Exclusive or Shared) with a matching tag completes in that cycle: `cpu_hit_o` is 1, `cpu_rdata_o` carries the word, `bus_req_o` is 0, and the line state is unchanged (a Modified line stays Modified).
- R3: A read miss raises `bus_req_o` and stalls. In its first granted cycle it drives command RD (code 1) with the line address `cpu_addr_i[ADDR_W-1:OFF_W]`, and returns word k of the line from `bus_rdata_i[k*DATA_W +: DATA_W]`, where k is `cpu_addr_i[OFF_W-1:0]` and the index is the low IDX_W bits of the line address. The line is filled Exclusive if `bus_shared_i` is 0 and Shared otherwise.
- R4: A write to an Exclusive or Modified line completes in that cycle with no bus request, and the line becomes Modified.
- R5: A write to a Shared line requests the bus. In its granted cycle it issues INV (code 3) for the line, completes, and leaves the line Modified with the word written.
- R6: A write miss issues RDX (code 2). The line is filled from `bus_rdata_i`, the written word is merged in, and the line becomes Modified.
- R7: A snooped RD (code 1) to a Modified line raises `snp_wb_o` with the line on `snp_wdata_o`, also raises `snp_shared_o`, and leaves the line Shared.
- R8: A snooped RD to an Exclusive or Shared line raises `snp_shared_o` without a write-back and leaves the line Shared.
- R9: A snooped RDX or INV to a valid line makes it Invalid. If the line was Modified, it is written back on `snp_wdata_o` with `snp_wb_o` raised.
- R10: A snoop acts on whole lines: invalidating a line loses every word of it. A snoop whose tag differs from the stored tag, and any snooped WB (code 4), changes nothing and raises neither `snp_shared_o` nor `snp_wb_o`.
- R11: A miss that lands on a Modified line of another tag first issues WB (code 4) with the victim's line address and data. It then issues the fill in the next granted cycle.
- R12: Transactions appear on `bus_cmd_o` (NONE is code 0) only in granted cycles, and the core stalls while the bus is not granted. In a cycle with `snp_valid_i` high, no processor request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request present, held until not stalled |
| cpu_we_i | input | 1 | 1 for write, 0 for read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_rdata_o | output | DATA_W | Read word, valid when a read completes |
| cpu_hit_o | output | 1 | Request completed this cycle without the bus |
| cpu_stall_o | output | 1 | Request present and not completing this cycle |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus granted for this cycle |
| bus_cmd_o | output | 3 | Issued command: 0 NONE, 1 RD, 2 RDX, 3 INV, 4 WB |
| bus_addr_o | output | ADDR_W-OFF_W | Line address of the issued command |
| bus_wdata_o | output | WORDS*DATA_W | Line data for WB |
| bus_rdata_i | input | WORDS*DATA_W | Line data returned for RD and RDX |
| bus_shared_i | input | 1 | A peer cache holds the line being read |
| snp_valid_i | input | 1 | Peer transaction observed this cycle |
| snp_cmd_i | input | 3 | Peer command, same codes as bus_cmd_o |
| snp_addr_i | input | ADDR_W-OFF_W | Peer line address |
| snp_shared_o | output | 1 | This cache holds the snooped line (reads) |
| snp_wb_o | output | 1 | This cache supplies dirty data for the snooped line |
| snp_wdata_o | output | WORDS*DATA_W | Supplied line data |

## Verification
The bench drives a long sweep of mixed processor and snoop operations. It aims them at three tags that collide on four indices, so that every state meets every operation, including dirty victims, stolen Shared lines and reads of other words in a line just invalidated. A reference model of states, tags, data and memory predicts each output. A controller that forgot to write back a victim, or that filled Exclusive while a peer held the line, would return stale data on a later read or a wrong value on a write-back. A controller that touched the bus for an Exclusive write, or let a hit complete during a snoop, would show a bus request, or a hit, in a cycle where the model expects none.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_INV  = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 5,
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              c_we_i,
  input  logic [IDX_W-1:0]  c_idx_i,
  input  line_st_e          c_st_i,
  input  logic [TAG_W-1:0]  c_tag_i,
  input  logic [LINE_W-1:0] c_data_i,
  input  logic              s_we_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  line_st_e          s_st_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [LINE_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [LINE_W-1:0] b_data_o
);
  line_st_e          st_arr   [LINES];
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [LINE_W-1:0] data_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] data_q;

    // snoop port wins; the core side never writes in a snoop cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= ST_I;
        tag_q  <= '0;
        data_q <= '0;
      end else if (s_we_i && s_idx_i == IDX_W'(g)) begin
        st_q <= s_st_i;
      end else if (c_we_i && c_idx_i == IDX_W'(g)) begin
        st_q   <= c_st_i;
        tag_q  <= c_tag_i;
        data_q <= c_data_i;
      end
    end

    assign st_arr[g]   = st_q;
    assign tag_arr[g]  = tag_q;
    assign data_arr[g] = data_q;
  end

  assign a_st_o   = st_arr[a_idx_i];
  assign a_tag_o  = tag_arr[a_idx_i];
  assign a_data_o = data_arr[a_idx_i];
  assign b_st_o   = st_arr[b_idx_i];
  assign b_tag_o  = tag_arr[b_idx_i];
  assign b_data_o = data_arr[b_idx_i];

  // R12
  store_port_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_we_i && c_we_i));
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [LINE_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              wb_o,
  output logic [LINE_W-1:0] wdata_o,
  output logic              upd_o,
  output line_st_e          nst_o
);
  logic held;
  assign held = snp_valid_i && line_st_i != ST_I && line_tag_i == snp_tag_i;

  always_comb begin
    shared_o = 1'b0;
    wb_o     = 1'b0;
    upd_o    = 1'b0;
    nst_o    = line_st_i;
    unique case (bus_cmd_e'(snp_cmd_i))
      CMD_RD: begin
        shared_o = held;
        wb_o     = held && line_st_i == ST_M;
        upd_o    = held && line_st_i != ST_S;
        nst_o    = ST_S;
      end
      CMD_RDX, CMD_INV: begin
        wb_o  = held && line_st_i == ST_M;
        upd_o = held;
        nst_o = ST_I;
      end
      default: ;
    endcase
  end

  assign wdata_o = line_data_i;

  // R10
  snp_wb_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 3'd4) |-> (!shared_o && !wb_o && !upd_o));

  // R7
  dirty_read_shares_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_o && snp_cmd_i == 3'd1) |-> shared_o);
endmodule

// File: rtl/coh_core_side.sv
module coh_core_side
  import mesi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORDS  = 2,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 5,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W,
  localparam int LA_W   = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_we_i,
  input  logic [TAG_W-1:0]  cpu_tag_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  input  logic [OFF_W-1:0]  cpu_off_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              snp_busy_i,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  input  logic [LINE_W-1:0] bus_rdata_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [LINE_W-1:0] line_data_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_hit_o,
  output logic              cpu_stall_o,
  output logic              bus_req_o,
  output logic [2:0]        bus_cmd_o,
  output logic [LA_W-1:0]   bus_addr_o,
  output logic [LINE_W-1:0] bus_wdata_o,
  output logic              we_o,
  output line_st_e          nst_o,
  output logic [TAG_W-1:0]  ntag_o,
  output logic [LINE_W-1:0] ndata_o
);
  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o,
                                                 input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = l;
    for (int w = 0; w < WORDS; w++)
      if (o == OFF_W'(w)) r[w*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int w = 0; w < WORDS; w++)
      if (o == OFF_W'(w)) r = l[w*DATA_W +: DATA_W];
    return r;
  endfunction

  logic     match, rd_hit, wr_fast, need_bus, go, victim, bus_done;
  bus_cmd_e cmd;

  assign match    = line_st_i != ST_I && line_tag_i == cpu_tag_i;
  assign rd_hit   = cpu_valid_i && !cpu_we_i && match;
  assign wr_fast  = cpu_valid_i && cpu_we_i && match &&
                    (line_st_i == ST_M || line_st_i == ST_E);
  assign need_bus = cpu_valid_i && !(rd_hit || wr_fast);
  assign go       = need_bus && bus_gnt_i && !snp_busy_i;
  assign victim   = line_st_i == ST_M && line_tag_i != cpu_tag_i;

  always_comb begin
    cmd         = CMD_NONE;
    bus_addr_o  = {cpu_tag_i, cpu_idx_i};
    we_o        = 1'b0;
    nst_o       = line_st_i;
    ntag_o      = cpu_tag_i;
    ndata_o     = line_data_i;
    cpu_rdata_o = get_word(line_data_i, cpu_off_i);
    bus_done    = 1'b0;
    if (wr_fast && !snp_busy_i) begin
      we_o    = 1'b1;
      nst_o   = ST_M;
      ndata_o = put_word(line_data_i, cpu_off_i, cpu_wdata_i);
    end
    if (go) begin
      we_o = 1'b1;
      if (victim) begin
        // dirty victim leaves first; fill follows on a later grant
        cmd        = CMD_WB;
        bus_addr_o = {line_tag_i, cpu_idx_i};
        nst_o      = ST_I;
        ntag_o     = line_tag_i;
      end else if (match) begin
        cmd      = CMD_INV;
        nst_o    = ST_M;
        ndata_o  = put_word(line_data_i, cpu_off_i, cpu_wdata_i);
        bus_done = 1'b1;
      end else if (cpu_we_i) begin
        cmd      = CMD_RDX;
        nst_o    = ST_M;
        ndata_o  = put_word(bus_rdata_i, cpu_off_i, cpu_wdata_i);
        bus_done = 1'b1;
      end else begin
        cmd         = CMD_RD;
        nst_o       = bus_shared_i ? ST_S : ST_E;
        ndata_o     = bus_rdata_i;
        cpu_rdata_o = get_word(bus_rdata_i, cpu_off_i);
        bus_done    = 1'b1;
      end
    end
  end

  assign bus_cmd_o   = cmd;
  assign bus_wdata_o = line_data_i;
  assign bus_req_o   = need_bus;
  assign cpu_hit_o   = (rd_hit || wr_fast) && !snp_busy_i;
  assign cpu_stall_o = cpu_valid_i && !(cpu_hit_o || bus_done);

  // R12
  bus_issue_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != 3'd0) |-> bus_gnt_i);

  // R12
  no_grant_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_valid_i && !bus_gnt_i && !cpu_hit_o) |-> cpu_stall_o);

  // R12
  snoop_blocks_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_busy_i |-> (!cpu_hit_o && bus_cmd_o == 3'd0));

  // R4
  hit_quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> (!bus_req_o && bus_cmd_o == 3'd0 && !cpu_stall_o));
endmodule

// File: rtl/coh_mesi_ctrl.sv
module coh_mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4,
  parameter int WORDS  = 2,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int LA_W   = ADDR_W - OFF_W,
  localparam int TAG_W  = LA_W - IDX_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_hit_o,
  output logic              cpu_stall_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [LA_W-1:0]   bus_addr_o,
  output logic [LINE_W-1:0] bus_wdata_o,
  input  logic [LINE_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [LA_W-1:0]   snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_wb_o,
  output logic [LINE_W-1:0] snp_wdata_o
);
  logic [OFF_W-1:0]  c_off;
  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  c_tag, s_tag;

  assign c_off = cpu_addr_i[OFF_W-1:0];
  assign c_idx = cpu_addr_i[OFF_W +: IDX_W];
  assign c_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign s_idx = snp_addr_i[IDX_W-1:0];
  assign s_tag = snp_addr_i[LA_W-1 -: TAG_W];

  line_st_e          a_st, b_st, c_nst, s_nst;
  logic [TAG_W-1:0]  a_tag, b_tag, c_ntag;
  logic [LINE_W-1:0] a_data, b_data, c_ndata;
  logic              c_we, s_upd;

  coh_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_store (
    .clk_i, .rst_ni,
    .c_we_i(c_we), .c_idx_i(c_idx), .c_st_i(c_nst), .c_tag_i(c_ntag), .c_data_i(c_ndata),
    .s_we_i(s_upd), .s_idx_i(s_idx), .s_st_i(s_nst),
    .a_idx_i(c_idx), .a_st_o(a_st), .a_tag_o(a_tag), .a_data_o(a_data),
    .b_idx_i(s_idx), .b_st_o(b_st), .b_tag_o(b_tag), .b_data_o(b_data)
  );

  coh_core_side #(
    .DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_core (
    .clk_i, .rst_ni,
    .cpu_valid_i, .cpu_we_i,
    .cpu_tag_i(c_tag), .cpu_idx_i(c_idx), .cpu_off_i(c_off),
    .cpu_wdata_i, .snp_busy_i(snp_valid_i),
    .bus_gnt_i, .bus_shared_i, .bus_rdata_i,
    .line_st_i(a_st), .line_tag_i(a_tag), .line_data_i(a_data),
    .cpu_rdata_o, .cpu_hit_o, .cpu_stall_o,
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_wdata_o,
    .we_o(c_we), .nst_o(c_nst), .ntag_o(c_ntag), .ndata_o(c_ndata)
  );

  coh_snoop_resp #(
    .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_cmd_i, .snp_tag_i(s_tag),
    .line_st_i(b_st), .line_tag_i(b_tag), .line_data_i(b_data),
    .shared_o(snp_shared_o), .wb_o(snp_wb_o), .wdata_o(snp_wdata_o),
    .upd_o(s_upd), .nst_o(s_nst)
  );

  // R12
  grant_vs_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_gnt_i && snp_valid_i));
endmodule

// File: tb/sim_coh_mesi_ctrl.sv
module sim_coh_mesi_ctrl;
  localparam int AW = 8, DW = 8, NL = 4, NW = 2;
  localparam int LAW = 7, LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cpu_valid = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0, cpu_rdata;
  logic          cpu_hit, cpu_stall, bus_req, bus_gnt = 0, bus_shared = 0;
  logic [2:0]    bus_cmd;
  logic [LAW-1:0] bus_addr;
  logic [LW-1:0] bus_wdata, bus_rdata;
  logic          snp_valid = 0;
  logic [2:0]    snp_cmd = 0;
  logic [LAW-1:0] snp_addr = 0;
  logic          snp_shared, snp_wb;
  logic [LW-1:0] snp_wdata;

  logic [LW-1:0] mem [2**LAW];
  assign bus_rdata = mem[bus_addr];

  coh_mesi_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_hit_o(cpu_hit),
    .cpu_stall_o(cpu_stall), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_wb_o(snp_wb), .snp_wdata_o(snp_wdata)
  );

  int checks = 0, fails = 0;
  // reference model: state 0 I, 1 S, 2 E, 3 M
  logic [1:0]  m_st   [NL];
  logic [4:0]  m_tag  [NL];
  logic [LW-1:0] m_data [NL];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wsel(input logic [LW-1:0] l, input logic o);
    return o ? l[15:8] : l[7:0];
  endfunction

  function automatic logic [LW-1:0] wput(input logic [LW-1:0] l, input logic o,
                                         input logic [DW-1:0] d);
    return o ? {d, l[7:0]} : {l[15:8], d};
  endfunction

  task automatic cpu_op(input logic we, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd, input int dly, input logic shr);
    logic [1:0] idx; logic [4:0] tag; logic off; logic [LAW-1:0] la; logic hit;
    idx = addr[2:1]; tag = addr[7:3]; off = addr[0]; la = addr[7:1];
    hit = m_st[idx] != 2'd0 && m_tag[idx] == tag;
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    bus_shared = shr; bus_gnt = 0;
    if (hit && (!we || m_st[idx] >= 2'd2)) begin
      #2;
      if (we) begin
        chk("R4 fast write hit", cpu_hit, 1);
        chk("R4 no bus req", bus_req, 0);
        m_st[idx] = 2'd3;
        m_data[idx] = wput(m_data[idx], off, wd);
      end else begin
        chk("R2 read hit", cpu_hit, 1);
        chk("R2 no bus req", bus_req, 0);
        chk("R2 read data", cpu_rdata, wsel(m_data[idx], off));
      end
      @(posedge clk);
    end else begin
      for (int c = 0; c < dly; c++) begin
        #2;
        chk("R12 stall without grant", cpu_stall, 1);
        chk("R12 request raised", bus_req, 1);
        chk("R12 no command without grant", bus_cmd, 0);
        @(posedge clk); @(negedge clk);
      end
      bus_gnt = 1;
      if (m_st[idx] == 2'd3 && m_tag[idx] != tag) begin
        #2;
        chk("R11 victim WB cmd", bus_cmd, 4);
        chk("R11 victim addr", bus_addr, {m_tag[idx], idx});
        chk("R11 victim data", bus_wdata, m_data[idx]);
        chk("R11 still stalled", cpu_stall, 1);
        @(posedge clk);
        mem[{m_tag[idx], idx}] = m_data[idx];
        m_st[idx] = 2'd0;
        @(negedge clk);
      end
      #2;
      if (hit) begin
        chk("R5 INV cmd", bus_cmd, 3);
        chk("R5 INV addr", bus_addr, la);
        chk("R5 done", cpu_stall, 0);
        m_st[idx] = 2'd3;
        m_data[idx] = wput(m_data[idx], off, wd);
      end else if (we) begin
        chk("R6 RDX cmd", bus_cmd, 2);
        chk("R6 RDX addr", bus_addr, la);
        chk("R6 done", cpu_stall, 0);
        m_st[idx] = 2'd3; m_tag[idx] = tag;
        m_data[idx] = wput(mem[la], off, wd);
      end else begin
        chk("R3 RD cmd", bus_cmd, 1);
        chk("R3 RD addr", bus_addr, la);
        chk("R3 fill data", cpu_rdata, wsel(mem[la], off));
        chk("R3 done", cpu_stall, 0);
        m_st[idx] = shr ? 2'd1 : 2'd2; m_tag[idx] = tag;
        m_data[idx] = mem[la];
      end
      @(posedge clk);
    end
    @(negedge clk);
    cpu_valid = 0; bus_gnt = 0;
  endtask

  task automatic snp_op(input logic [2:0] cmd, input logic [LAW-1:0] la);
    logic [1:0] idx; logic [4:0] tag; logic hit; logic esh, ewb; string r;
    idx = la[1:0]; tag = la[6:2];
    hit = m_st[idx] != 2'd0 && m_tag[idx] == tag;
    esh = hit && cmd == 3'd1;
    ewb = hit && m_st[idx] == 2'd3 && (cmd >= 3'd1 && cmd <= 3'd3);
    if (!hit || cmd == 3'd4 || cmd == 3'd0) r = "R10 snoop no effect";
    else if (cmd == 3'd1 && m_st[idx] == 2'd3) r = "R7 snoop read of M";
    else if (cmd == 3'd1) r = "R8 snoop read of E/S";
    else r = "R9 snoop claim";
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = la;
    #2;
    chk(r, snp_shared, esh);
    chk(r, snp_wb, ewb);
    if (ewb) chk(r, snp_wdata, m_data[idx]);
    @(posedge clk);
    if (ewb) mem[la] = m_data[idx];
    if (hit && cmd == 3'd1) m_st[idx] = 2'd1;
    if (hit && (cmd == 3'd2 || cmd == 3'd3)) m_st[idx] = 2'd0;
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int a = 0; a < 2**LAW; a++) mem[a] = {8'(a * 7 + 3), 8'(a ^ 8'h5A)};
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; m_data[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: nothing held after reset
    for (int i = 0; i < NL; i++) snp_op(3'd1, LAW'(i));
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = 8'h00; #2;
    chk("R1 first access misses", cpu_hit, 0);
    chk("R1 first access requests", bus_req, 1);
    @(negedge clk) cpu_valid = 0;

    // R4/R7: exclusive fill, quiet write, dirty share on snoop
    cpu_op(0, 8'h04, 0, 1, 0);
    cpu_op(1, 8'h05, 8'hC3, 0, 0);
    snp_op(3'd1, 7'h02);
    cpu_op(0, 8'h05, 0, 0, 0);
    cpu_op(1, 8'h04, 8'h11, 2, 0);       // R5 via Shared

    // R10: invalidate of one word loses the whole line
    cpu_op(1, 8'h10, 8'h77, 0, 0);
    snp_op(3'd3, 7'h08);
    cpu_op(0, 8'h11, 0, 0, 1);
    snp_op(3'd2, 7'h28);                 // other tag, same index
    snp_op(3'd4, 7'h08);                 // WB ignored
    cpu_op(0, 8'h10, 0, 0, 0);

    // R11: dirty victim then fill
    cpu_op(1, 8'h02, 8'hA5, 0, 0);
    cpu_op(0, 8'h0A, 0, 1, 0);
    cpu_op(0, 8'h02, 0, 0, 0);

    // R12: snoop cycle blocks a hit
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = 8'h02;
    snp_valid = 1; snp_cmd = 3'd4; snp_addr = 7'h55;
    #2;
    chk("R12 hit held off by snoop", cpu_hit, 0);
    chk("R12 stall during snoop", cpu_stall, 1);
    @(negedge clk); snp_valid = 0; #2;
    chk("R12 hit after snoop", cpu_hit, 1);
    chk("R2 data after snoop", cpu_rdata, wsel(m_data[1], 0));
    @(negedge clk); cpu_valid = 0;

    // sweep
    seed = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] op; logic [AW-1:0] ad; logic [4:0] tg;
      seed = seed * 32'd1664525 + 32'd1013904223;
      op = seed[30:28];
      tg = 5'(seed[20:16] % 3);
      ad = {tg, seed[12:11], seed[9]};
      case (op)
        3'd0, 3'd1, 3'd2: cpu_op(0, ad, 8'h0, int'(seed[6:5]) % 3, seed[4]);
        3'd3, 3'd4: cpu_op(1, ad, seed[27:20], int'(seed[6:5]) % 3, seed[4]);
        3'd5: snp_op(3'd1, ad[7:1]);
        3'd6: snp_op(seed[3] ? 3'd2 : 3'd3, ad[7:1]);
        default: snp_op(3'd4, ad[7:1]);
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule